// File: doc/BRIEF.md
# Code-Favouring Re-Reference Replacement Controller

This block holds the replacement state of one set-associative cache level. Each way of each set carries a valid bit and a 2-bit re-reference prediction. Hits pull a line's prediction to the nearest level. Miss lookups return a victim way one cycle later. Fills install a line with an insertion prediction that depends on whether the request fetched instruction code or data.

Code lines start one step nearer than data lines. Under the same aging and eviction rules, code therefore outlives data in the set. The surrounding cache controller issues one request per cycle. It first issues a miss lookup. It then issues a fill to the same set, naming the way that the lookup returned. Tags, data storage and the memory side are not part of this block.

Top module: `rrip_code_repl`

## Requirements
- R1: Predictions are 2-bit values, with 0 for immediate, 1 for intermediate, 2 for far and 3 for distant. After reset every way of every set is invalid with prediction 3, and `victim_valid` is low.
- R2: Among valid ways, only a way whose prediction is 3 (after any aging applied by the same lookup) is returned as victim.
- R3: A miss lookup on a fully valid set with no way at 3 adds the same amount to every way's prediction. That amount brings the set's largest prediction to exactly 3. The victim is the lowest-numbered way that reached 3.
- R4: A hit request (`req_op` = 0) sets the named way's prediction to 0. Other ways keep their values.
- R5: A fill request (`req_op` = 2) marks the named way valid. It inserts prediction 2 when `req_code` is 1 and prediction 3 when `req_code` is 0.
- R6: A miss lookup on a set that has an invalid way returns the lowest-numbered invalid way.
- R7: When several valid ways are at 3, the lowest-numbered one is the victim.
- R8: `victim_valid` is high for exactly the one cycle after each accepted miss lookup (`req_op` = 1), and low in every other cycle. Code 3 and `req_valid` low are idle.
- R9: A miss lookup that returns an invalid way leaves every prediction of that set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 hit, 1 miss lookup, 2 fill, 3 idle |
| req_set | input | SET_W (4) | Set index of the request |
| req_way | input | WAY_W (2) | Way hit, or way being filled |
| req_code | input | 1 | Fill is for instruction code (1) or data (0) |
| victim_valid | output | 1 | Victim way is valid this cycle |
| victim_way | output | WAY_W (2) | Chosen victim way |

## Verification
The embedded properties check several rules in every cycle. A returned valid victim sits at distant in the state that follows it. The strobe appears one cycle after every lookup and at no other time. A hit leaves its way at immediate. A fill leaves its way valid at the insertion level for its request type.

Other behaviours show only through the bench's scenarios against its reference model. These are the exact aging amount, the tie order among distant ways, the priority of invalid ways, and the absence of aging when an invalid way is taken. The bench covers them with directed sequences and with long random runs of hits, lookups and fills.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  localparam int RRPV_W = 2;

  typedef enum logic [1:0] {
    OP_HIT  = 2'd0,
    OP_MISS = 2'd1,
    OP_FILL = 2'd2,
    OP_IDLE = 2'd3
  } rrip_op_e;

  localparam logic [RRPV_W-1:0] RRPV_NEAR = 2'd0;
  localparam logic [RRPV_W-1:0] RRPV_FAR  = 2'd2;
  localparam logic [RRPV_W-1:0] RRPV_DIST = 2'd3;
endpackage

// File: rtl/rrip_victim_pick.sv
module rrip_victim_pick
  import rrip_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]             row_vld,
  input  logic [NUM_WAYS-1:0][RRPV_W-1:0] row_rrpv,
  output logic [WAY_W-1:0]                pick_way,
  output logic [RRPV_W-1:0]               age_amt,
  output logic                            any_invalid
);
  logic [WAY_W-1:0]  inv_way;
  logic [WAY_W-1:0]  max_way;
  logic [RRPV_W-1:0] row_max;

  always_comb begin
    any_invalid = 1'b0;
    inv_way     = '0;
    row_max     = '0;
    max_way     = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!row_vld[i]) begin
        any_invalid = 1'b1;
        inv_way     = WAY_W'(i);
      end
    end
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (row_rrpv[i] > row_max) row_max = row_rrpv[i];
    end
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (row_rrpv[i] == row_max) max_way = WAY_W'(i);
    end
    age_amt  = RRPV_DIST - row_max;
    pick_way = any_invalid ? inv_way : max_way;
  end
endmodule

// File: rtl/rrip_row_update.sv
module rrip_row_update
  import rrip_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                            op_en,
  input  rrip_op_e                        op,
  input  logic [WAY_W-1:0]                way,
  input  logic                            code,
  input  logic [NUM_WAYS-1:0]             row_vld,
  input  logic [NUM_WAYS-1:0][RRPV_W-1:0] row_rrpv,
  input  logic [RRPV_W-1:0]               age_amt,
  input  logic                            any_invalid,
  output logic [NUM_WAYS-1:0]             nxt_vld,
  output logic [NUM_WAYS-1:0][RRPV_W-1:0] nxt_rrpv,
  output logic                            row_we
);
  always_comb begin
    nxt_vld  = row_vld;
    nxt_rrpv = row_rrpv;
    row_we   = op_en && (op != OP_IDLE);
    for (int w = 0; w < NUM_WAYS; w++) begin
      unique case (op)
        OP_HIT: begin
          if (way == WAY_W'(w)) nxt_rrpv[w] = RRPV_NEAR;
        end
        OP_MISS: begin
          // aging never wraps: the largest value lands exactly on distant
          if (!any_invalid) nxt_rrpv[w] = row_rrpv[w] + age_amt;
        end
        OP_FILL: begin
          if (way == WAY_W'(w)) begin
            nxt_vld[w]  = 1'b1;
            nxt_rrpv[w] = code ? RRPV_FAR : RRPV_DIST;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rrip_code_repl.sv
module rrip_code_repl
  import rrip_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = $clog2(NUM_SETS),
  parameter int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [SET_W-1:0] req_set,
  input  logic [WAY_W-1:0] req_way,
  input  logic             req_code,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  logic [NUM_WAYS-1:0]             vld_q  [NUM_SETS];
  logic [NUM_WAYS-1:0][RRPV_W-1:0] rrpv_q [NUM_SETS];

  logic [NUM_WAYS-1:0]             row_vld, nxt_vld;
  logic [NUM_WAYS-1:0][RRPV_W-1:0] row_rrpv, nxt_rrpv;
  logic [WAY_W-1:0]                pick_way;
  logic [RRPV_W-1:0]               age_amt;
  logic                            any_invalid;
  logic                            row_we;
  logic                            miss_go;
  rrip_op_e                        op;

  logic             victim_valid_q;
  logic [WAY_W-1:0] victim_way_q;
  logic [SET_W-1:0] vset_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign op       = rrip_op_e'(req_op);
  assign row_vld  = vld_q[req_set];
  assign row_rrpv = rrpv_q[req_set];
  assign miss_go  = req_valid && (op == OP_MISS);

  rrip_victim_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
    .row_vld     (row_vld),
    .row_rrpv    (row_rrpv),
    .pick_way    (pick_way),
    .age_amt     (age_amt),
    .any_invalid (any_invalid)
  );

  rrip_row_update #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_upd (
    .op_en       (req_valid),
    .op          (op),
    .way         (req_way),
    .code        (req_code),
    .row_vld     (row_vld),
    .row_rrpv    (row_rrpv),
    .age_amt     (age_amt),
    .any_invalid (any_invalid),
    .nxt_vld     (nxt_vld),
    .nxt_rrpv    (nxt_rrpv),
    .row_we      (row_we)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic set_en;
    assign set_en = row_we && (req_set == SET_W'(s));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]  <= '0;
        rrpv_q[s] <= {NUM_WAYS{RRPV_DIST}};
      end else if (set_en) begin
        vld_q[s]  <= nxt_vld;
        rrpv_q[s] <= nxt_rrpv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_valid_q <= 1'b0;
      victim_way_q   <= '0;
      vset_q         <= '0;
    end else begin
      victim_valid_q <= miss_go;
      if (miss_go) begin
        victim_way_q <= pick_way;
        vset_q       <= req_set;
      end
    end
  end

  assign victim_valid = victim_valid_q;
  assign victim_way   = victim_way_q;

  AST_VICTIM_DISTANT: assert property (@(posedge clk) disable iff (!rst_ni)
    victim_valid_q |-> (!vld_q[vset_q][victim_way_q] ||
                        rrpv_q[vset_q][victim_way_q] == RRPV_DIST)); // R2
  AST_MISS_STROBE: assert property (@(posedge clk) disable iff (!rst_ni)
    miss_go |=> victim_valid_q); // R8
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_ni)
    !miss_go |=> !victim_valid_q); // R8
  AST_HIT_NEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && op == OP_HIT) |=>
      rrpv_q[$past(req_set)][$past(req_way)] == RRPV_NEAR); // R4
  AST_FILL_INSERT: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && op == OP_FILL) |=>
      (vld_q[$past(req_set)][$past(req_way)] &&
       rrpv_q[$past(req_set)][$past(req_way)] ==
         ($past(req_code) ? RRPV_FAR : RRPV_DIST))); // R5
endmodule

// File: tb/sim_rrip_code_repl.sv
`timescale 1ns/1ps
module sim_rrip_code_repl;
  localparam int NS = 16;
  localparam int NW = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_op;
  logic [3:0] req_set;
  logic [1:0] req_way;
  logic       req_code;
  logic       victim_valid;
  logic [1:0] victim_way;

  int errs = 0;
  int chks = 0;
  bit ref_vld [NS][NW];
  int ref_rr  [NS][NW];

  always #2.5 clk = ~clk;

  rrip_code_repl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_set(req_set), .req_way(req_way), .req_code(req_code),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  task automatic check(string tag, int act, int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_max(int s);
    int m = 0;
    for (int w = 0; w < NW; w++) if (ref_rr[s][w] > m) m = ref_rr[s][w];
    return m;
  endfunction

  function automatic int ref_first_inv(int s);
    for (int w = 0; w < NW; w++) if (!ref_vld[s][w]) return w;
    return -1;
  endfunction

  function automatic int ref_pick(int s);
    int m = ref_max(s);
    if (ref_first_inv(s) >= 0) return ref_first_inv(s);
    for (int w = 0; w < NW; w++) if (ref_rr[s][w] == m) return w;
    return 0;
  endfunction

  function automatic string miss_tag(int s);
    int n = 0;
    if (ref_first_inv(s) >= 0) return "R6";
    for (int w = 0; w < NW; w++) if (ref_rr[s][w] == 3) n++;
    if (n > 1) return "R7";
    if (n == 1) return "R2";
    return "R3";
  endfunction

  // one request; inputs change at the falling edge, outputs read one cycle on
  task automatic do_req(int op, int s, int w, bit code, string tag, output int vic);
    int exp_w;
    string t;
    @(negedge clk);
    req_valid = (op != 3);
    req_op    = 2'(op);
    req_set   = 4'(s);
    req_way   = 2'(w);
    req_code  = code;
    exp_w     = ref_pick(s);
    t         = (tag != "") ? tag : miss_tag(s);
    @(negedge clk);
    vic = victim_way;
    if (op == 1) begin
      check({t, "/R8 strobe"}, victim_valid, 1);
      check({t, " victim"}, victim_way, exp_w);
      if (ref_first_inv(s) < 0) begin
        int d = 3 - ref_max(s);
        for (int k = 0; k < NW; k++) ref_rr[s][k] += d;
      end
    end else begin
      check("R8 no strobe", victim_valid, 0);
      if (op == 0) ref_rr[s][w] = 0;
      if (op == 2) begin
        ref_vld[s][w] = 1'b1;
        ref_rr[s][w]  = code ? 2 : 3;
      end
    end
    req_valid = 1'b0;
  endtask

  task automatic miss_fill(int s, bit code, string tag, output int vic);
    int dummy;
    do_req(1, s, 0, 1'b0, tag, vic);
    do_req(2, s, vic, code, "R5", dummy);
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, chks + 1);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd3;
    req_set = '0; req_way = '0; req_code = 1'b0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin ref_vld[s][w] = 0; ref_rr[s][w] = 3; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset strobe low", victim_valid, 0);

    // R1 / R6: fresh set gives way 0
    do_req(1, 5, 0, 0, "R1", v);
    // fill set 0 with data, then tie among distant ways (R7)
    for (int i = 0; i < NW; i++) miss_fill(0, 0, "R6", v);
    do_req(1, 0, 0, 0, "R7", v);
    // R4: hit way 0 then lookup skips it
    do_req(0, 0, 0, 0, "R4", v);
    do_req(1, 0, 0, 0, "R4", v);
    // R5: code ways at far, one data way at distant wins
    for (int i = 0; i < NW; i++) miss_fill(1, (i != 2), "R6", v);
    do_req(1, 1, 0, 0, "R5", v);
    // R3: all code, one hit, then aging by one
    for (int i = 0; i < NW; i++) miss_fill(2, 1, "R6", v);
    do_req(0, 2, 1, 0, "R4", v);
    do_req(1, 2, 0, 0, "R3", v);
    do_req(1, 2, 0, 0, "R3", v);
    // R9: lookup with invalid way present must not age way 0 (code, far)
    miss_fill(3, 1, "R6", v);
    do_req(1, 3, 0, 0, "R9", v);
    for (int i = 1; i < NW; i++) miss_fill(3, 0, "R6", v);
    do_req(1, 3, 0, 0, "R9", v);
    check("R9 victim not aged way", v, 1);
    // R8: idle cycle and reserved code give no strobe
    do_req(3, 4, 0, 0, "R8", v);

    for (int it = 0; it < 3000; it++) begin
      int r = $urandom % 10;
      int s = $urandom % NS;
      int w = $urandom % NW;
      if (r < 4 && ref_vld[s][w]) do_req(0, s, w, 0, "R4", v);
      else if (r < 9) miss_fill(s, 1'($urandom % 2), "", v);
      else do_req(3, s, w, 0, "R8", v);
    end

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule